// File: doc/BRIEF.md
# Sixteen-Lane Hybrid Prefix-Sum Network

This block computes an inclusive prefix sum over a vector of sixteen words. Output lane j carries the sum of input lanes 0 through j, taken modulo 2^WIDTH. The lanes are split into four groups of four. Each group is first scanned on its own by two levels of recursive doubling.

Two fan levels then combine the groups. The total of one group is broadcast to every lane of the neighbouring group or groups, so the group totals never need a scan of their own. The network has four adder levels and thirty-six two-input adders.

A vector is presented together with a valid flag. When the pipelined variant is selected, a register follows each of the four adder levels. The valid flag then travels with the data and emerges four cycles later. When registers are disabled, the network is purely combinational. A new vector may be accepted on every cycle.

Top module: `sk_scan16`

## Requirements
- R1: Whenever out_vld is high, output lane j (bits j*WIDTH +: WIDTH) equals the sum modulo 2^WIDTH of input lanes 0..j of the vector accepted together with it.
- R2: Output lane 0 equals input lane 0 of the same vector, unchanged.
- R3: Output lane 15 equals the sum modulo 2^WIDTH of all sixteen input lanes.
- R4: With PIPELINED=1, out_vld equals in_vld delayed by exactly 4 clock cycles. Vectors on consecutive valid cycles come out in the same order, with no gaps or duplicates. With PIPELINED=0 the delay is 0.
- R5: While rst is high, and until the first valid vector has crossed the pipeline, out_vld is low.
- R6: Sums that exceed 2^WIDTH-1 wrap. With every input at all ones, lane j equals (2^WIDTH-1)*(j+1) mod 2^WIDTH.
- R7: If only input lane k is nonzero with value v, then output lanes below k are zero and lanes k..15 all equal v.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input vector valid |
| in_data | input | 16*WIDTH | Sixteen input words, lane 0 in the low bits |
| out_vld | output | 1 | Result vector valid |
| out_data | output | 16*WIDTH | Sixteen inclusive sums, lane 0 in the low bits |

## Verification
The bench drives single-hot vectors at every lane position. A fan that broadcasts the wrong group total, or that reaches the wrong groups, shows up as a step in the wrong lane or a step missing. All-ones inputs test wrap-around: a carry that is lost or sign-extended across the adders gives a wrong value in the high lanes. Random vectors, sent back to back and with gaps in the valid flag, catch a level whose register is missing, or a valid flag that runs one cycle ahead of or behind its data. Either fault appears as results that are shifted, repeated or out of order.

// File: rtl/sk_scan_pkg.sv
package sk_scan_pkg;
    localparam int LANES      = 16;
    localparam int GRP        = 4;
    localparam int GROUPS     = LANES / GRP;
    localparam int LEVELS     = 4;
    localparam int DBL_LEVELS = 2;
    localparam int ADDERS     = 36;

    // distance used by a recursive-doubling level inside a group
    function automatic int dbl_dist(input int lvl);
        return 1 << lvl;
    endfunction

    // number of groups sharing one broadcast total at a fan level
    function automatic int fan_span(input int lvl);
        return 1 << (lvl - DBL_LEVELS);
    endfunction
endpackage

// File: rtl/sk_dbl_level.sv
module sk_dbl_level
    import sk_scan_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DIST  = 1
) (
    input  logic [LANES-1:0][WIDTH-1:0] a,
    output logic [LANES-1:0][WIDTH-1:0] y
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if ((i % GRP) >= DIST) begin : g_add
            assign y[i] = a[i] + a[i-DIST];
        end else begin : g_pass
            assign y[i] = a[i];
        end
    end
endmodule

// File: rtl/sk_fan_level.sv
module sk_fan_level
    import sk_scan_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int SPAN  = 1
) (
    input  logic [LANES-1:0][WIDTH-1:0] a,
    output logic [LANES-1:0][WIDTH-1:0] y
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int G   = i / GRP;
        localparam int BLK = G / SPAN;
        if ((BLK % 2) == 1) begin : g_add
            localparam int SRC = BLK * SPAN * GRP - 1;
            assign y[i] = a[i] + a[SRC];
        end else begin : g_pass
            assign y[i] = a[i];
        end
    end
endmodule

// File: rtl/sk_stage.sv
module sk_stage
    import sk_scan_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter bit REG   = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        d_vld,
    input  logic [LANES-1:0][WIDTH-1:0] d,
    output logic                        q_vld,
    output logic [LANES-1:0][WIDTH-1:0] q
);
    if (REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q_vld <= 1'b0;
                q     <= '0;
            end else begin
                q_vld <= d_vld;
                q     <= d;
            end
        end
    end else begin : g_wire
        assign q_vld = d_vld;
        assign q     = d;
    end
endmodule

// File: rtl/sk_scan16.sv
module sk_scan16
    import sk_scan_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter bit PIPELINED = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_vld,
    input  logic [LANES*WIDTH-1:0] in_data,
    output logic                   out_vld,
    output logic [LANES*WIDTH-1:0] out_data
);
    logic [LEVELS:0][LANES-1:0][WIDTH-1:0] st_d;
    logic [LEVELS:0]                       st_v;
    logic [LEVELS-1:0][LANES-1:0][WIDTH-1:0] sum_d;

    assign st_d[0] = in_data;
    assign st_v[0] = in_vld;

    for (genvar k = 0; k < LEVELS; k++) begin : g_level
        if (k < DBL_LEVELS) begin : g_dbl
            sk_dbl_level #(.WIDTH(WIDTH), .DIST(dbl_dist(k))) i_dbl (
                .a(st_d[k]),
                .y(sum_d[k])
            );
        end else begin : g_fan
            sk_fan_level #(.WIDTH(WIDTH), .SPAN(fan_span(k))) i_fan (
                .a(st_d[k]),
                .y(sum_d[k])
            );
        end
        sk_stage #(.WIDTH(WIDTH), .REG(PIPELINED)) i_stage (
            .clk  (clk),
            .rst  (rst),
            .d_vld(st_v[k]),
            .d    (sum_d[k]),
            .q_vld(st_v[k+1]),
            .q    (st_d[k+1])
        );
    end

    assign out_vld  = st_v[LEVELS];
    assign out_data = st_d[LEVELS];
endmodule

// File: rtl/sk_scan16_chk.sv
module sk_scan16_chk
    import sk_scan_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter bit PIPELINED = 1'b1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_vld,
    input logic [LANES*WIDTH-1:0] in_data,
    input logic                   out_vld,
    input logic [LANES*WIDTH-1:0] out_data
);
    localparam int LAT = PIPELINED ? LEVELS : 0;

    logic [LANES-1:0][WIDTH-1:0] din_dl [LAT+1];
    logic                        vld_dl [LAT+1];
    logic [LANES-1:0][WIDTH-1:0] o_w;
    logic [WIDTH-1:0]            in_total;
    logic [3:0]                  warm_cnt;
    logic                        warm;

    assign din_dl[0] = in_data;
    assign vld_dl[0] = in_vld;
    assign o_w       = out_data;

    always_comb begin
        in_total = '0;
        for (int i = 0; i < LANES; i++) in_total = in_total + in_data[i*WIDTH +: WIDTH];
    end

    logic [WIDTH-1:0] tot_dl [LAT+1];
    assign tot_dl[0] = in_total;

    for (genvar k = 1; k <= LAT; k++) begin : g_dl
        always_ff @(posedge clk) begin
            din_dl[k] <= din_dl[k-1];
            vld_dl[k] <= rst ? 1'b0 : vld_dl[k-1];
            tot_dl[k] <= tot_dl[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) warm_cnt <= '0;
        else if (int'(warm_cnt) < LAT) warm_cnt <= warm_cnt + 4'd1;
    end
    assign warm = int'(warm_cnt) >= LAT;

    AST_VLD_DELAY: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_vld == vld_dl[LAT]));                              // R4

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!warm && PIPELINED) |-> !out_vld);                               // R5

    AST_LANE0_PASS: assert property (@(posedge clk) disable iff (rst)
        (warm && out_vld) |-> (o_w[0] == din_dl[LAT][0]));               // R2

    AST_TOTAL_LAST: assert property (@(posedge clk) disable iff (rst)
        (warm && out_vld) |-> (o_w[LANES-1] == tot_dl[LAT]));            // R3

    for (genvar j = 1; j < LANES; j++) begin : g_step
        AST_LANE_STEP: assert property (@(posedge clk) disable iff (rst)
            (warm && out_vld) |-> (WIDTH'(o_w[j] - o_w[j-1]) == din_dl[LAT][j])); // R1
    end
endmodule

bind sk_scan16 sk_scan16_chk #(.WIDTH(WIDTH), .PIPELINED(PIPELINED)) i_sk_scan16_chk (.*);

// File: tb/test_sk_scan16.sv
module test_sk_scan16;
    localparam int W  = 16;
    localparam int N  = 16;
    localparam int LAT = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_vld = 1'b0;
    logic [N*W-1:0] in_data = '0;
    logic           out_vld;
    logic [N*W-1:0] out_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic           exp_v [8];
    logic [N*W-1:0] exp_d [8];
    string          exp_t [8];

    always #2.5 clk = ~clk;

    sk_scan16 #(.WIDTH(W), .PIPELINED(1'b1)) i_sk_scan16 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
        .out_vld(out_vld), .out_data(out_data)
    );

    function automatic logic [N*W-1:0] ref_scan(input logic [N*W-1:0] v);
        logic [W-1:0] acc = '0;
        logic [N*W-1:0] r;
        for (int i = 0; i < N; i++) begin
            acc = acc + v[i*W +: W];
            r[i*W +: W] = acc;
        end
        return r;
    endfunction

    function automatic logic [N*W-1:0] rand_vec();
        logic [N*W-1:0] r;
        for (int i = 0; i < N; i++) r[i*W +: W] = W'($urandom);
        return r;
    endfunction

    task automatic check_out();
        int s = (cyc + 8 - LAT) % 8;
        checks++;
        if (out_vld !== exp_v[s]) begin
            fails++;
            $display("FAIL R4 cycle %0d out_vld act=%b exp=%b", cyc, out_vld, exp_v[s]);
        end
        if (exp_v[s] === 1'b1) begin
            checks++;
            if (out_data !== exp_d[s]) begin
                fails++;
                for (int i = 0; i < N; i++)
                    if (out_data[i*W +: W] !== exp_d[s][i*W +: W]) begin
                        $display("FAIL %s lane %0d act=%h exp=%h", exp_t[s], i,
                                 out_data[i*W +: W], exp_d[s][i*W +: W]);
                        break;
                    end
            end
            checks++;
            if (out_data[0 +: W] !== exp_d[s][0 +: W]) begin
                fails++;
                $display("FAIL R2 lane0 act=%h exp=%h", out_data[0 +: W], exp_d[s][0 +: W]);
            end
            checks++;
            if (out_data[(N-1)*W +: W] !== exp_d[s][(N-1)*W +: W]) begin
                fails++;
                $display("FAIL R3 lane15 act=%h exp=%h", out_data[(N-1)*W +: W],
                         exp_d[s][(N-1)*W +: W]);
            end
        end
    endtask

    task automatic step(input logic v, input logic [N*W-1:0] d, input string tag);
        @(negedge clk);
        check_out();
        exp_v[cyc % 8] = v;
        exp_d[cyc % 8] = ref_scan(d);
        exp_t[cyc % 8] = tag;
        in_vld  = v;
        in_data = d;
        cyc++;
    endtask

    initial begin
        logic [N*W-1:0] vec;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) begin
            exp_v[i] = 1'b0;
            exp_d[i] = '0;
            exp_t[i] = "R1";
        end
        rst = 1'b1;
        in_vld = 1'b1;
        in_data = rand_vec();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            checks++;
            if (out_vld !== 1'b0) begin
                fails++;
                $display("FAIL R5 out_vld during reset act=%b exp=0", out_vld);
            end
        end
        in_vld = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        // R5: quiet after reset until the first vector crosses
        step(1'b0, '0, "R5");
        step(1'b1, '0, "R1");
        step(1'b1, {N{ {W{1'b1}} }}, "R6");
        vec = '0;
        for (int i = 0; i < N; i++) vec[i*W +: W] = 16'h7fff;
        step(1'b1, vec, "R6");
        // R7: single-hot at every lane
        for (int k = 0; k < N; k++) begin
            vec = '0;
            vec[k*W +: W] = W'($urandom_range(1, 65535));
            step(1'b1, vec, "R7");
        end
        // R4: back-to-back distinct vectors
        for (int i = 0; i < 24; i++) step(1'b1, rand_vec(), "R4");
        // R1: random vectors with gaps in the valid flag
        for (int i = 0; i < 400; i++)
            step(($urandom % 4) != 0, rand_vec(), "R1");
        for (int i = 0; i < 8; i++) step(1'b0, rand_vec(), "R4");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired act=hung exp=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule